// File: doc/BRIEF.md
# Serial Register Bank Slave with Alternating Address Mode

This block is a two-wire serial slave that lets a bus master reach a bank of 128 eight-bit registers. It runs entirely on the system clock. The serial clock and data lines are oversampled through a synchronizer, and bus events are recognised from the synchronized levels. A transaction opens with a start condition and a 7-bit device identifier plus a direction bit. Once the identifier matches, the next byte of a write is a register address byte, and its low seven bits steer the data that follows.

The static `auto_inc` input selects how data bytes are handled. With it low, the write stream alternates: each data byte is followed by a new register address byte. With it high, every byte after the address byte is data, and the address advances by one per byte, wrapping at the top of the bank. Reads return register contents MSB first until the master declines to acknowledge. The data line is open drain. The block only ever pulls it low, which it signals by raising `sda_oe`.

Top module: `serial_regbank_slave`

## Requirements
- R1: After reset `sda_oe` is 0 and every register reads as 0x00.
- R2: The first byte after a start is the 7-bit device identifier (default 0x3A) in bits 7..1, with the direction in bit 0 (0 = write, 1 = read). On a match the slave holds the data line low for the whole high phase of the ninth clock. On a mismatch it leaves the line released until the next start or stop, so the bytes that follow are neither acknowledged nor written.
- R3: In a write, the byte after the identifier is a register address byte. Its bits 6..0 load the address register and its bit 7 is ignored. The next byte is stored in the addressed register. The slave acknowledges both bytes.
- R4: With `auto_inc` = 0, the byte after each data byte is taken as a new register address byte, followed by a new data byte, until a stop or start.
- R5: With `auto_inc` = 1, every byte after the register address byte is data. The address register increases by one after each data byte and wraps from 127 to 0.
- R6: In a read, the slave sends the addressed register MSB first. After each byte the master acknowledges, the next byte is sent from the following address when `auto_inc` = 1, or from the same address when `auto_inc` = 0.
- R7: When the master does not acknowledge a read byte, the slave releases the data line and keeps it released until the next start or stop.
- R8: A stop returns the slave to idle, and clock pulses without a new start are ignored. A repeated start restarts identifier matching.
- R9: Apart from the cycle after a start or stop, `sda_oe` changes only while the synchronized serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level (the wired-AND of all drivers) |
| auto_inc | input | 1 | 1 selects streaming data with address increment, 0 selects alternating address/data |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
A data byte completes with a register write and an address register update in the same clock. When `auto_inc` is high and the address is 127, that update is the wrap to 0. The bench streams three bytes starting at address 126. It then reads them back from 126 and checks that the third byte went to register 0 and that register 127 kept its own value. A second collision is a master acknowledge that meets the next read load on one falling clock edge. This is judged by comparing consecutive read bytes against registers written earlier in both modes.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVID,
        ST_RAB,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } rbs_state_e;

    typedef struct packed {
        logic scl_lvl;
        logic sda_lvl;
        logic scl_rise;
        logic scl_fall;
        logic start_ev;
        logic stop_ev;
    } bus_ev_t;

endpackage

// File: rtl/rbs_line_sync.sv
module rbs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_in,
    input  logic            sda_in,
    output rbs_pkg::bus_ev_t ev
);
    localparam int CW = STAGES + 1;

    typedef struct packed {
        logic [CW-1:0] scl;
        logic [CW-1:0] sda;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d     = chain_q;
        chain_d.scl = {chain_q.scl[CW-2:0], scl_in};
        chain_d.sda = {chain_q.sda[CW-2:0], sda_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '{scl: '1, sda: '1};
        else        chain_q <= chain_d;
    end

    logic scl_now, scl_prev, sda_now, sda_prev;
    assign scl_now  = chain_q.scl[CW-2];
    assign scl_prev = chain_q.scl[CW-1];
    assign sda_now  = chain_q.sda[CW-2];
    assign sda_prev = chain_q.sda[CW-1];

    always_comb begin
        ev.scl_lvl  = scl_now;
        ev.sda_lvl  = sda_now;
        ev.scl_rise = scl_now & ~scl_prev;
        ev.scl_fall = ~scl_now & scl_prev;
        ev.start_ev = scl_now & scl_prev & sda_prev & ~sda_now;
        ev.stop_ev  = scl_now & scl_prev & ~sda_prev & sda_now;
    end

    // A start and a stop can never be reported together
    assert_one_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev.start_ev && ev.stop_ev));

endmodule

// File: rtl/rbs_regfile.sv
module rbs_regfile #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

    assert_write_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/rbs_proto_fsm.sv
module rbs_proto_fsm
    import rbs_pkg::*;
#(
    parameter int            AW     = 7,
    parameter int            DW     = 8,
    parameter logic [DW-2:0] DEV_ID = 7'h3A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_ev_t       ev,
    input  logic          auto_inc,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          sda_oe
);
    localparam int CNTW = $clog2(DW) + 1;
    localparam logic [CNTW-1:0] FULL = CNTW'(DW);

    typedef struct packed {
        rbs_state_e    state;
        rbs_state_e    after;
        logic [DW-1:0] sh;
        logic [CNTW-1:0] bits;
        logic [AW-1:0] addr;
        logic          oe;
        logic          nack;
    } ctx_t;

    ctx_t d, q;

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_addr = q.addr;
        wr_data = q.sh;
        if (ev.stop_ev) begin
            d.state = ST_IDLE;
            d.oe    = 1'b0;
        end else if (ev.start_ev) begin
            d.state = ST_DEVID;
            d.bits  = '0;
            d.oe    = 1'b0;
        end else begin
            unique case (q.state)
                ST_DEVID, ST_RAB, ST_WDATA: begin
                    if (ev.scl_rise && q.bits < FULL) begin
                        d.sh   = {q.sh[DW-2:0], ev.sda_lvl};
                        d.bits = q.bits + 1'b1;
                    end else if (ev.scl_fall && q.bits == FULL) begin
                        d.bits = '0;
                        if (q.state == ST_DEVID) begin
                            if (q.sh[DW-1:1] == DEV_ID) begin
                                d.oe    = 1'b1;
                                d.state = ST_ACK;
                                d.after = q.sh[0] ? ST_RDATA : ST_RAB;
                            end else begin
                                d.state = ST_IGNORE;
                            end
                        end else if (q.state == ST_RAB) begin
                            d.addr  = q.sh[AW-1:0];
                            d.oe    = 1'b1;
                            d.state = ST_ACK;
                            d.after = ST_WDATA;
                        end else begin
                            wr_en   = 1'b1;
                            d.addr  = auto_inc ? q.addr + 1'b1 : q.addr;
                            d.oe    = 1'b1;
                            d.state = ST_ACK;
                            d.after = auto_inc ? ST_WDATA : ST_RAB;
                        end
                    end
                end
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        d.state = q.after;
                        d.bits  = '0;
                        d.oe    = 1'b0;
                        if (q.after == ST_RDATA) begin
                            d.sh = rd_data;
                            d.oe = ~rd_data[DW-1];
                        end
                    end
                end
                ST_RDATA: begin
                    if (ev.scl_rise) begin
                        d.bits = q.bits + 1'b1;
                    end else if (ev.scl_fall) begin
                        if (q.bits == FULL) begin
                            d.oe    = 1'b0;
                            d.bits  = '0;
                            d.state = ST_RACK;
                            d.addr  = auto_inc ? q.addr + 1'b1 : q.addr;
                        end else begin
                            d.sh = {q.sh[DW-2:0], 1'b0};
                            d.oe = ~q.sh[DW-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (ev.scl_rise) begin
                        d.nack = ev.sda_lvl;
                    end else if (ev.scl_fall) begin
                        if (q.nack) begin
                            d.state = ST_IGNORE;
                            d.oe    = 1'b0;
                        end else begin
                            d.state = ST_RDATA;
                            d.sh    = rd_data;
                            d.oe    = ~rd_data[DW-1];
                            d.bits  = '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, after: ST_IDLE, sh: '0, bits: '0,
                   addr: '0, oe: 1'b0, nack: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign rd_addr = q.addr;

    assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> $past(!ev.scl_lvl || ev.start_ev || ev.stop_ev));

    assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev.stop_ev |=> q.state == ST_IDLE);

    assert_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IGNORE || q.state == ST_IDLE) |-> !q.oe);

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && auto_inc) |=> q.addr == $past(q.addr) + AW'(1));

    assert_alternate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !auto_inc) |=> (q.after == ST_RAB && q.addr == $past(q.addr)));

endmodule

// File: rtl/serial_regbank_slave.sv
module serial_regbank_slave #(
    parameter int            AW          = 7,
    parameter int            DW          = 8,
    parameter logic [DW-2:0] DEV_ID      = 7'h3A,
    parameter int            SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic auto_inc,
    output logic sda_oe
);
    rbs_pkg::bus_ev_t ev;
    logic [AW-1:0]    rd_addr;
    logic [DW-1:0]    rd_data;
    logic             wr_en;
    logic [AW-1:0]    wr_addr;
    logic [DW-1:0]    wr_data;

    rbs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_in(scl_in),
        .sda_in(sda_in),
        .ev    (ev)
    );

    rbs_proto_fsm #(.AW(AW), .DW(DW), .DEV_ID(DEV_ID)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .auto_inc(auto_inc),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sda_oe  (sda_oe)
    );

    rbs_regfile #(.AW(AW), .DW(DW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

endmodule

// File: tb/test_serial_regbank_slave.sv
`timescale 1ns/1ps
module test_serial_regbank_slave;

    localparam int H = 8;
    localparam logic [6:0] ID = 7'h3A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic auto_inc = 1'b0;
    logic sda_oe;
    logic sda_bus;

    always #4 clk = ~clk;

    assign sda_bus = ~(m_low | sda_oe);

    serial_regbank_slave i_serial_regbank_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_in  (m_scl),
        .sda_in  (sda_bus),
        .auto_inc(auto_inc),
        .sda_oe  (sda_oe)
    );

    typedef struct {
        string tag;
        int    val;
    } item_t;

    item_t exp_q[$];
    int    obs_q[$];
    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;

    task automatic chk(input string tag, input int act, input int expv);
        exp_q.push_back('{tag: tag, val: expv});
        obs_q.push_back(act);
    endtask

    // Monitor: pops expected and observed items in order and compares them
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && obs_q.size() > 0) begin
                item_t e;
                int    a;
                e = exp_q.pop_front();
                a = obs_q.pop_front();
                vectors++;
                if (a != e.val) begin
                    miscompares++;
                    $display("FAIL %s: got %0h expected %0h", e.tag, a, e.val);
                end
            end
        end
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        m_low = 1'b0; w(H);
        m_scl = 1'b1; w(H);
        m_low = 1'b1; w(H);
        m_scl = 1'b0; w(H);
    endtask

    task automatic bus_stop;
        m_low = 1'b1; w(H);
        m_scl = 1'b1; w(H);
        m_low = 1'b0; w(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; w(H);
            m_scl = 1'b1;  w(H);
            m_scl = 1'b0;  w(H);
        end
        m_low = 1'b0; w(H);
        m_scl = 1'b1; w(H/2);
        acked = (sda_bus == 1'b0);
        w(H/2);
        m_scl = 1'b0; w(H);
    endtask

    task automatic recv_byte(input logic ack_it, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            w(H);
            m_scl = 1'b1; w(H/2);
            b[i] = sda_bus;
            w(H/2);
            m_scl = 1'b0;
        end
        w(2);
        m_low = ack_it; w(H);
        m_scl = 1'b1;   w(H);
        m_scl = 1'b0;   w(2);
        m_low = 1'b0;   w(H);
    endtask

    // Write transaction with address byte, leaving the bus open
    task automatic set_addr(input logic [7:0] rab, input string tag);
        logic a;
        bus_start();
        send_byte({ID, 1'b0}, a); chk({tag, " devid ack"}, a, 1);
        send_byte(rab, a);        chk({tag, " rab ack"}, a, 1);
    endtask

    // Read n bytes from register address rab, NACK on the last one
    task automatic read_seq(input logic [7:0] rab, input int n,
                            input logic [7:0] e0, input logic [7:0] e1,
                            input logic [7:0] e2, input string tag);
        logic a;
        logic [7:0] b;
        logic [7:0] ev[3];
        ev[0] = e0; ev[1] = e1; ev[2] = e2;
        set_addr(rab, tag);
        bus_start();
        send_byte({ID, 1'b1}, a); chk({tag, " read devid ack"}, a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            chk($sformatf("%s byte %0d", tag, k), b, ev[k]);
        end
        bus_stop();
    endtask

    initial begin
        logic a;
        logic [7:0] b;
        w(5);
        rst_n = 1'b1;
        w(5);
        chk("R1 sda_oe after reset", sda_oe, 0);

        // R1: reset contents
        auto_inc = 1'b1;
        read_seq(8'h05, 2, 8'h00, 8'h00, 8'h00, "R1 reset regs");

        // R3/R4: alternating writes, bit 7 of the address byte ignored
        auto_inc = 1'b0;
        set_addr(8'h03, "R3 alt");
        send_byte(8'hA5, a); chk("R3 data ack", a, 1);
        send_byte(8'h90, a); chk("R4 second rab ack", a, 1);
        send_byte(8'h3C, a); chk("R4 second data ack", a, 1);
        send_byte(8'h04, a); chk("R4 third rab ack", a, 1);
        send_byte(8'h5A, a); chk("R4 third data ack", a, 1);
        bus_stop();

        // R6: streaming read with increment
        auto_inc = 1'b1;
        read_seq(8'h03, 3, 8'hA5, 8'h5A, 8'h00, "R6 inc read");
        read_seq(8'h10, 1, 8'h3C, 8'h00, 8'h00, "R3 top bit ignored");
        read_seq(8'h11, 1, 8'h00, 8'h00, 8'h00, "R4 rab not stored as data");

        // R5: streaming write wrapping from 127 to 0
        set_addr(8'h7E, "R5 wrap");
        send_byte(8'h11, a); chk("R5 data0 ack", a, 1);
        send_byte(8'h22, a); chk("R5 data1 ack", a, 1);
        send_byte(8'h33, a); chk("R5 data2 ack", a, 1);
        bus_stop();
        read_seq(8'h7E, 3, 8'h11, 8'h22, 8'h33, "R5 wrap readback");

        // R6: no increment repeats the same register
        auto_inc = 1'b0;
        read_seq(8'h7F, 3, 8'h22, 8'h22, 8'h22, "R6 repeat read");

        // R2: mismatched identifier leaves the bus alone
        bus_start();
        send_byte({7'h55, 1'b0}, a); chk("R2 wrong id no ack", a, 0);
        send_byte(8'h03, a);          chk("R2 ignored rab", a, 0);
        send_byte(8'hFF, a);          chk("R2 ignored data", a, 0);
        bus_stop();
        auto_inc = 1'b1;
        read_seq(8'h03, 1, 8'hA5, 8'h00, 8'h00, "R2 register untouched");

        // R8: repeated start after a mismatch restarts matching
        bus_start();
        send_byte({7'h11, 1'b1}, a); chk("R8 wrong id", a, 0);
        bus_start();
        send_byte({ID, 1'b0}, a);    chk("R8 restart match", a, 1);
        bus_stop();

        // R8: clocks after a stop without a start are ignored
        send_byte({ID, 1'b0}, a);    chk("R8 idle after stop", a, 0);

        // R7: after NACK the slave keeps the line released
        set_addr(8'h03, "R7");
        bus_start();
        send_byte({ID, 1'b1}, a); chk("R7 read devid ack", a, 1);
        recv_byte(1'b0, b);       chk("R7 byte before nack", b, 8'hA5);
        recv_byte(1'b0, b);       chk("R7 line released", b, 8'hFF);
        chk("R9 oe released at end", sda_oe, 0);
        bus_stop();

        w(20);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule